// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the register side of taking an exception in a MIPS-style system control coprocessor. A pipeline presents a one-cycle request carrying a cause code, a delay-slot flag, the PC of the faulting instruction and, for address faults, the faulting address. On the clock edge that samples the request the block updates Cause, EPC, the exception-level bit of Status, and for TLB misses also BadVAddr, Context and EntryHi. It then loads a new fetch PC chosen from the current error level, the boot-vector select bits and the class of the exception.

The resulting register values are visible on read ports. A single-cycle `redirect_valid` pulse tells the fetch stage to restart at `fetch_pc`. A level-2 request whose class is not recognised changes nothing and pulses `level2_err` instead. A small write port lets the surrounding core load Status, Context, EntryHi and EPC. Returning from an exception and the TLB lookup belong to other blocks.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `fetch_pc`=0xBFC00000, Status=0x70400004, `prid_o`=0x00002E20, `config_o`=0x440, every other register zero, and no pulse. Status bit fields used by this block: IE bit 0, EXL bit 1, ERL bit 2, BEV bit 22, DEV bit 23.
- R2: A request taken in any case except an unknown level-2 class writes the low 16 bits of `req_code` into Cause[15:0] and clears Cause[30:16].
- R3: With ERL=0, the vector offset follows the field `req_code[6:2]`: values 2 or 3 (TLB refill) give 0x000, value 0 (interrupt) gives 0x200, and any other value gives 0x180. The base is 0x80000000 when BEV=0 and 0xBFC00200 when BEV=1.
- R4: With ERL=1, the class field `req_code[17:15]` decides the outcome. Class 0 or 1 (reset/NMI) sets `fetch_pc` to 0xBFC00000 and leaves EPC, EXL and Cause[31] unchanged. Class 2 (performance counter) uses offset 0x080. Class 3 (debug) uses offset 0x100. The base comes from DEV, with the same two base values that BEV selects in R3.
- R5: If EXL was 0 and the request is not reset/NMI, EXL becomes 1. EPC becomes `req_pc`-4 with Cause[31]=1 when `req_bd` is set, and `req_pc` with Cause[31]=0 otherwise.
- R6: If EXL was already 1, EPC and Cause[31] keep their values and the offset is 0x180, whatever the class.
- R7: A request with `req_tlb_miss` set loads BadVAddr with `req_addr`. Context keeps its bits under mask 0xFF80000F and takes `(req_addr >> 9) & 0x007FFFF0` into the rest. EntryHi takes `req_addr[31:13]` and keeps its own bits [12:0].
- R8: Register updates, `fetch_pc` and `redirect_valid` all appear together in the cycle after the request edge. `redirect_valid` is high for exactly one cycle per accepted request.
- R9: A level-2 request of class 4 to 7 changes no register and no PC. It pulses `level2_err` for one cycle and does not raise `redirect_valid`.
- R10: The write port (`wr_sel` 0 Status, 1 Context, 2 EntryHi, 3 EPC) loads the selected register on the following edge. A request in the same cycle takes priority, and the write is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle exception request strobe |
| req_code | input | 32 | Cause code with level-2 class field |
| req_bd | input | 1 | Faulting instruction sits in a delay slot |
| req_pc | input | 32 | PC of the faulting instruction |
| req_tlb_miss | input | 1 | Request is a TLB miss; update address registers |
| req_addr | input | 32 | Faulting virtual address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 Status, 1 Context, 2 EntryHi, 3 EPC |
| wr_data | input | 32 | Write data |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| level2_err | output | 1 | One-cycle pulse for an unknown level-2 class |
| fetch_pc | output | 32 | Current fetch PC |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | EPC register |
| status_o | output | 32 | Status register |
| badvaddr_o | output | 32 | BadVAddr register |
| context_o | output | 32 | Context register |
| entryhi_o | output | 32 | EntryHi register |
| prid_o | output | 32 | Processor id register (constant) |
| config_o | output | 32 | Config register (constant) |

## Verification
The properties assume that `req_valid` is a clean strobe and that a write and a request in the same cycle resolve in favour of the request. They also assume that Status changes only through the write port or through the EXL rule. The stimulus keeps to this. It drives every input half a cycle before the sampling edge and always drops the strobes after one cycle. Each Status configuration is loaded through the write port, with idle cycles between requests, so that every EXL, ERL, BEV and DEV combination is reached legally before the sweep of code classes and delay-slot values.

// File: rtl/exc_pkg.sv
// Package: shared constants and types for the exception entry sequencer.
// Assumes a 32-bit register file with fixed coprocessor bit positions.
package exc_pkg;
    localparam int XW = 32;

    // Status bit positions
    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_BEV = 22;
    localparam int ST_DEV = 23;

    // Cause delay-slot bit
    localparam int CA_BD = 31;

    // Write port selector
    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_CONTEXT = 2'd1,
        SEL_ENTRYHI = 2'd2,
        SEL_EPC     = 2'd3
    } wsel_e;

    // Outcome of vector selection for one request
    typedef struct packed {
        logic          unknown;   // level-2 class not recognised
        logic          hard_rst;  // reset/NMI class
        logic          save_epc;  // EXL was clear: capture EPC and BD
        logic [XW-1:0] target;    // new fetch PC
    } vec_dec_t;
endpackage

// File: rtl/exc_vector_sel.sv
// Module: exc_vector_sel
// Purely combinational. Picks the offset and base for an exception request
// from the error level, boot-vector selects, EXL and the code class.
// Assumes the status input is the value before the request takes effect.
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] BASE_LOW  = 32'h8000_0000,
    parameter logic [XW-1:0] BASE_BOOT = 32'hBFC0_0200,
    parameter logic [XW-1:0] RESET_PC  = 32'hBFC0_0000
) (
    input  logic [XW-1:0] code,
    input  logic [XW-1:0] status,
    output vec_dec_t      dec
);
    localparam logic [XW-1:0] OFF_REFILL = 32'h000;
    localparam logic [XW-1:0] OFF_PERF   = 32'h080;
    localparam logic [XW-1:0] OFF_DEBUG  = 32'h100;
    localparam logic [XW-1:0] OFF_GEN    = 32'h180;
    localparam logic [XW-1:0] OFF_INT    = 32'h200;

    logic [4:0]    exc_field;
    logic [2:0]    cls_field;
    logic [XW-1:0] offset;
    logic          use_low;
    logic          lvl2;

    assign exc_field = code[6:2];
    assign cls_field = code[17:15];
    assign lvl2      = status[ST_ERL];

    // Decide class, raw offset and base select
    always_comb begin
        dec.unknown  = 1'b0;
        dec.hard_rst = 1'b0;
        offset       = OFF_GEN;
        if (!lvl2) begin
            use_low = !status[ST_BEV];
            if (exc_field == 5'd2 || exc_field == 5'd3)
                offset = OFF_REFILL;
            else if (exc_field == 5'd0)
                offset = OFF_INT;
            else
                offset = OFF_GEN;
        end else begin
            use_low = !status[ST_DEV];
            case (cls_field)
                3'd0, 3'd1: dec.hard_rst = 1'b1;
                3'd2:       offset = OFF_PERF;
                3'd3:       offset = OFF_DEBUG;
                default:    dec.unknown = 1'b1;
            endcase
        end
        // Nested exception forces the general offset
        if (status[ST_EXL])
            offset = OFF_GEN;
        dec.save_epc = !status[ST_EXL] && !dec.hard_rst;
        if (dec.hard_rst)
            dec.target = RESET_PC;
        else
            dec.target = (use_low ? BASE_LOW : BASE_BOOT) + offset;
    end
endmodule

// File: rtl/exc_tlb_fields.sv
// Module: exc_tlb_fields
// Combinational next values of Context and EntryHi for a TLB miss.
// Assumes a 4 KB page pair layout: VPN2 in EntryHi[31:13].
module exc_tlb_fields
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] CTX_KEEP = 32'hFF80_000F,
    parameter int            CTX_SHR  = 9,
    parameter int            VPN_LSB  = 13
) (
    input  logic [XW-1:0] addr,
    input  logic [XW-1:0] ctx_cur,
    input  logic [XW-1:0] eh_cur,
    output logic [XW-1:0] ctx_nxt,
    output logic [XW-1:0] eh_nxt
);
    localparam logic [XW-1:0] CTX_FILL = ~CTX_KEEP;
    localparam logic [XW-1:0] EH_LOW   = (32'h1 << VPN_LSB) - 32'h1;

    // Merge faulting address bits into the kept fields
    always_comb begin
        ctx_nxt = (ctx_cur & CTX_KEEP) | ((addr >> CTX_SHR) & CTX_FILL);
        eh_nxt  = (addr & ~EH_LOW) | (eh_cur & EH_LOW);
    end
endmodule

// File: rtl/exc_cp0_regs.sv
// Module: exc_cp0_regs
// Holds the coprocessor registers touched on exception entry plus the
// fetch PC. Applies a request (priority) or a write port update per clock.
// Assumes dec and TLB next values are computed from the current state.
module exc_cp0_regs
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] RESET_PC     = 32'hBFC0_0000,
    parameter logic [XW-1:0] RESET_STATUS = 32'h7040_0004,
    parameter int            CODE_BITS    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [XW-1:0] req_code,
    input  logic          req_bd,
    input  logic [XW-1:0] req_pc,
    input  logic          req_tlb_miss,
    input  logic [XW-1:0] req_addr,
    input  vec_dec_t      dec,
    input  logic [XW-1:0] ctx_nxt,
    input  logic [XW-1:0] eh_nxt,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [XW-1:0] wr_data,
    output logic          redirect_valid,
    output logic          level2_err,
    output logic [XW-1:0] fetch_pc,
    output logic [XW-1:0] cause_q,
    output logic [XW-1:0] epc_q,
    output logic [XW-1:0] status_q,
    output logic [XW-1:0] badvaddr_q,
    output logic [XW-1:0] context_q,
    output logic [XW-1:0] entryhi_q
);
    localparam int MID_BITS = XW - 1 - CODE_BITS;

    logic          take;
    logic          bd_next;
    logic [XW-1:0] cause_next;
    wsel_e         sel;

    assign take = req_valid && !dec.unknown;
    assign sel  = wsel_e'(wr_sel);

    // Build next Cause: new code, cleared middle, BD per EXL rule
    always_comb begin
        bd_next    = dec.save_epc ? req_bd : cause_q[CA_BD];
        cause_next = {bd_next, {MID_BITS{1'b0}}, req_code[CODE_BITS-1:0]};
    end

    // Register state: reset, request commit, or write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc   <= RESET_PC;
            status_q   <= RESET_STATUS;
            cause_q    <= '0;
            epc_q      <= '0;
            badvaddr_q <= '0;
            context_q  <= '0;
            entryhi_q  <= '0;
        end else if (take) begin
            fetch_pc <= dec.target;
            cause_q  <= cause_next;
            if (dec.save_epc) begin
                epc_q            <= req_bd ? (req_pc - 32'd4) : req_pc;
                status_q[ST_EXL] <= 1'b1;
            end
            if (req_tlb_miss) begin
                badvaddr_q <= req_addr;
                context_q  <= ctx_nxt;
                entryhi_q  <= eh_nxt;
            end
        end else if (wr_en && !req_valid) begin
            case (sel)
                SEL_STATUS:  status_q  <= wr_data;
                SEL_CONTEXT: context_q <= wr_data;
                SEL_ENTRYHI: entryhi_q <= wr_data;
                SEL_EPC:     epc_q     <= wr_data;
                default:     ;
            endcase
        end
    end

    // One-cycle outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            level2_err     <= 1'b0;
        end else begin
            redirect_valid <= take;
            level2_err     <= req_valid && dec.unknown;
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Module: exc_entry_unit (top)
// Exception entry sequencer: decodes the vector, merges TLB miss fields and
// commits all register updates and the fetch redirect in one clock.
// Assumes req_valid is a single-cycle strobe; a same-cycle write is dropped.
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter logic [31:0] RESET_PC     = 32'hBFC0_0000,
    parameter logic [31:0] RESET_STATUS = 32'h7040_0004,
    parameter logic [31:0] PRID_VAL     = 32'h0000_2E20,
    parameter logic [31:0] CONFIG_VAL   = 32'h0000_0440,
    parameter logic [31:0] BASE_LOW     = 32'h8000_0000,
    parameter logic [31:0] BASE_BOOT    = 32'hBFC0_0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_code,
    input  logic        req_bd,
    input  logic [31:0] req_pc,
    input  logic        req_tlb_miss,
    input  logic [31:0] req_addr,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        redirect_valid,
    output logic        level2_err,
    output logic [31:0] fetch_pc,
    output logic [31:0] cause_o,
    output logic [31:0] epc_o,
    output logic [31:0] status_o,
    output logic [31:0] badvaddr_o,
    output logic [31:0] context_o,
    output logic [31:0] entryhi_o,
    output logic [31:0] prid_o,
    output logic [31:0] config_o
);
    vec_dec_t    dec;
    logic [31:0] ctx_nxt;
    logic [31:0] eh_nxt;

    assign prid_o   = PRID_VAL;
    assign config_o = CONFIG_VAL;

    exc_vector_sel #(
        .BASE_LOW (BASE_LOW),
        .BASE_BOOT(BASE_BOOT),
        .RESET_PC (RESET_PC)
    ) u_vec (
        .code  (req_code),
        .status(status_o),
        .dec   (dec)
    );

    exc_tlb_fields u_tlb (
        .addr   (req_addr),
        .ctx_cur(context_o),
        .eh_cur (entryhi_o),
        .ctx_nxt(ctx_nxt),
        .eh_nxt (eh_nxt)
    );

    exc_cp0_regs #(
        .RESET_PC    (RESET_PC),
        .RESET_STATUS(RESET_STATUS)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_code      (req_code),
        .req_bd        (req_bd),
        .req_pc        (req_pc),
        .req_tlb_miss  (req_tlb_miss),
        .req_addr      (req_addr),
        .dec           (dec),
        .ctx_nxt       (ctx_nxt),
        .eh_nxt        (eh_nxt),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .redirect_valid(redirect_valid),
        .level2_err    (level2_err),
        .fetch_pc      (fetch_pc),
        .cause_q       (cause_o),
        .epc_q         (epc_o),
        .status_q      (status_o),
        .badvaddr_q    (badvaddr_o),
        .context_q     (context_o),
        .entryhi_q     (entryhi_o)
    );
endmodule

// File: rtl/exc_entry_checker.sv
// Module: exc_entry_checker
// Temporal properties over the ports of exc_entry_unit, bound below.
module exc_entry_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_code,
    input logic        wr_en,
    input logic        redirect_valid,
    input logic        level2_err,
    input logic [31:0] fetch_pc,
    input logic [31:0] cause_o,
    input logic [31:0] epc_o,
    input logic [31:0] status_o
);
    // R1: reset values follow a reset edge
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc == 32'hBFC0_0000 && status_o == 32'h7040_0004
                    && !redirect_valid && !level2_err));

    // R8 and R9: the two pulses never coincide
    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && level2_err));

    // R8: every request yields exactly one outcome pulse next cycle
    assert_outcome_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (redirect_valid || level2_err));

    // R6: EXL already set keeps EPC and the BD bit
    assert_nested_keeps_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && status_o[1]) |=> ($stable(epc_o) && $stable(cause_o[31])));

    // R5: level-0 request with EXL clear sets EXL
    assert_exl_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !status_o[2] && !status_o[1]) |=> status_o[1]);

    // R9: an idle cycle leaves PC and Cause untouched
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wr_en) |=> ($stable(fetch_pc) && $stable(cause_o)));
endmodule

bind exc_entry_unit exc_entry_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_code      (req_code),
    .wr_en         (wr_en),
    .redirect_valid(redirect_valid),
    .level2_err    (level2_err),
    .fetch_pc      (fetch_pc),
    .cause_o       (cause_o),
    .epc_o         (epc_o),
    .status_o      (status_o)
);

// File: tb/exc_entry_unit_test.sv
// Bench: sweeps Status modes x code classes x delay-slot flag, plus TLB
// miss field merges, against a model computed from the requirements.
module exc_entry_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_code = '0;
    logic        req_bd = 1'b0;
    logic [31:0] req_pc = '0;
    logic        req_tlb_miss = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        redirect_valid, level2_err;
    logic [31:0] fetch_pc, cause_o, epc_o, status_o, badvaddr_o;
    logic [31:0] context_o, entryhi_o, prid_o, config_o;

    int checks = 0;
    int failures = 0;

    // model state
    logic [31:0] m_pc, m_cause, m_epc, m_status, m_bad, m_ctx, m_eh;

    always #2.5 clk = ~clk;

    exc_entry_unit uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_status = d;
            2'd1: m_ctx = d;
            2'd2: m_eh = d;
            default: m_epc = d;
        endcase
    endtask

    // Apply the requirements to the model and return expected outcome
    task automatic model_req(input logic [31:0] code, input logic bd, input logic [31:0] pc,
                             input logic tlb, input logic [31:0] addr,
                             output logic exp_redir, output logic exp_err);
        logic lvl2, exl, rst_cls, low;
        logic [31:0] off;
        int ef, cf;
        lvl2 = m_status[2]; exl = m_status[1];
        ef = int'(code[6:2]); cf = int'(code[17:15]);
        rst_cls = 1'b0; exp_err = 1'b0; off = 32'h180;
        if (!lvl2) begin
            low = !m_status[22];
            if (ef == 2 || ef == 3) off = 32'h0;
            else if (ef == 0) off = 32'h200;
        end else begin
            low = !m_status[23];
            if (cf <= 1) rst_cls = 1'b1;
            else if (cf == 2) off = 32'h80;
            else if (cf == 3) off = 32'h100;
            else exp_err = 1'b1;
        end
        exp_redir = !exp_err;
        if (exp_err) return;
        if (exl) off = 32'h180;
        m_pc = rst_cls ? 32'hBFC0_0000 : ((low ? 32'h8000_0000 : 32'hBFC0_0200) + off);
        m_cause = {m_cause[31], 15'd0, code[15:0]};
        if (!exl && !rst_cls) begin
            m_status[1] = 1'b1;
            m_epc = bd ? pc - 32'd4 : pc;
            m_cause[31] = bd;
        end
        if (tlb) begin
            m_bad = addr;
            m_ctx = (m_ctx & 32'hFF80_000F) | ((addr >> 9) & 32'h007F_FFF0);
            m_eh = {addr[31:13], m_eh[12:0]};
        end
    endtask

    task automatic do_req(input logic [31:0] code, input logic bd, input logic [31:0] pc,
                          input logic tlb, input logic [31:0] addr, input string tag);
        logic er, ee;
        model_req(code, bd, pc, tlb, addr, er, ee);
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_bd = bd; req_pc = pc;
        req_tlb_miss = tlb; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0; req_tlb_miss = 1'b0;
        check({tag, " R8 redirect"}, {31'd0, redirect_valid}, {31'd0, er});
        check({tag, " R9 err"}, {31'd0, level2_err}, {31'd0, ee});
        check({tag, " R3/R4 pc"}, fetch_pc, m_pc);
        check({tag, " R2 cause"}, cause_o, m_cause);
        check({tag, " R5/R6 epc"}, epc_o, m_epc);
        check({tag, " R5 status"}, status_o, m_status);
        if (tlb) begin
            check({tag, " R7 badvaddr"}, badvaddr_o, m_bad);
            check({tag, " R7 context"}, context_o, m_ctx);
            check({tag, " R7 entryhi"}, entryhi_o, m_eh);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pc", fetch_pc, 32'hBFC0_0000);
        check("R1 status", status_o, 32'h7040_0004);
        check("R1 prid", prid_o, 32'h0000_2E20);
        check("R1 config", config_o, 32'h0000_0440);
        check("R1 cause", cause_o, 32'h0);
        check("R1 pulses", {30'd0, redirect_valid, level2_err}, 32'h0);
        m_pc = 32'hBFC0_0000; m_status = 32'h7040_0004;
        m_cause = '0; m_epc = '0; m_bad = '0; m_ctx = '0; m_eh = '0;

        // Sweep: Status modes x class x exc field x bd
        for (int st = 0; st < 16; st++) begin
            for (int cf = 0; cf < 8; cf++) begin
                for (int ef = 0; ef < 32; ef += 1) begin
                    for (int bd = 0; bd < 2; bd++) begin
                        logic [31:0] sv, code, pc;
                        sv = 32'h0000_0001;
                        sv[1] = st[0]; sv[2] = st[1]; sv[22] = st[2]; sv[23] = st[3];
                        write_reg(2'd0, sv);
                        write_reg(2'd3, 32'hA5A5_0F00 + 32'(ef));
                        code = (32'(cf) << 15) | (32'(ef) << 2) | 32'h00C0_0000;
                        pc = 32'h0040_0000 + 32'((st * 256 + cf * 32 + ef) * 8);
                        do_req(code, bd[0], pc, 1'b0, 32'h0, "sweep");
                    end
                end
            end
        end

        // R7: TLB miss merges with preset Context/EntryHi
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = 32'h1357_9BDF * 32'(k + 1) ^ 32'hF0F0_3C3C;
            write_reg(2'd0, 32'h0040_0000);
            write_reg(2'd1, 32'hFFFF_FFFF ^ (32'(k) << 20));
            write_reg(2'd2, 32'h0000_1ABC ^ 32'(k * 77));
            do_req(32'h0000_0008 | 32'(k[0]) << 2, k[1], 32'h8800_0000, 1'b1, a, "tlb");
        end

        // R10: write dropped when a request shares the cycle
        write_reg(2'd0, 32'h0000_0000);
        @(negedge clk);
        req_valid = 1'b1; req_code = 32'h0000_0024; req_bd = 1'b0; req_pc = 32'h1000_0000;
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R10 request wins epc", epc_o, 32'h1000_0000);
        check("R10 pc", fetch_pc, 32'h8000_0180);
        @(negedge clk);
        check("R8 single pulse", {31'd0, redirect_valid}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule